// File: doc/BRIEF.md
# Converter Command and Mode Controller

This block is the digital control core of a converter that a host reaches over a serial link. The host sends 8-bit frames over an SPI slave port in mode 0 (data sampled on the rising clock edge, most significant bit first). The first byte of every chip-select window is a command. A command can change the operating mode, write one of a few configuration registers, or read a register or the latest conversion result. The SPI pins are brought into the core clock domain through two-flop synchronizers, so the SPI clock must run well below the core clock.

The controller has four modes: settling, standby, conversion and power-down. The current mode drives the `pwr_mode` output, which the analog enables decode. A settling period follows power-on and every wake-up, and its length is set by parameters. A sample strobe stands in for the analog modulator. The strobe is accepted only in conversion mode. It latches a new result and pulls the active-low data-ready flag low. Reading the result returns the flag to high.

Top module: `cvc_core`

## Requirements
- R1: After `rst_n` is released, `pwr_mode` is 3 (settling), `drdy_n` is 1 and `spi_miso` is 0. Register 1 (filter control) holds 0x05 and registers 0, 2 and 3 hold 0x00.
- R2: Settling lasts CORE_KHZ*SETTLE_US/1000 core cycles after reset release or after a wake-up. It then ends in standby (0). If a START (0x08) or CALIBRATE (0x0C) arrived during settling and was not cancelled, it ends in conversion (1) instead.
- R3: Frames are 8 bits, MSB first, in SPI mode 0. Raising chip-select in the middle of a frame discards the partial byte. Command codes with no defined meaning are ignored.
- R4: In standby, START 0x08 or CALIBRATE 0x0C switches to conversion (1) as soon as the command byte completes. POWER_DOWN 0x04 switches to power-down (2). Standby with no command stays in standby.
- R5: In conversion, STOP 0x0A returns to standby and POWER_DOWN 0x04 enters power-down. START and CALIBRATE keep the controller in conversion.
- R6: In power-down, only WAKE_UP 0x02 has an effect, and it starts a new settling period. Writes, RESET and mode commands are ignored, and reads shift out 0x00.
- R7: Command 0x40|a followed by a data byte writes register a (a = 0..3). Command 0x80|a shifts out register a on MISO during the next byte.
- R8: Writes to register 1 (filter control) are ignored while in conversion. Writes to the other registers still take effect in conversion.
- R9: Register contents are unchanged across power-down and wake-up.
- R10: RESET 0x01, when not in power-down, returns all registers and the result to their defaults and sets `drdy_n` high. From conversion it also returns to standby.
- R11: A `smp_stb` pulse in conversion stores `smp_data` as the result and drives `drdy_n` low. Pulses in any other mode are ignored.
- R12: Command 0xA0 (address 0x20) shifts out the last stored result in any mode except power-down, and sets `drdy_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when not selected |
| smp_stb | input | 1 | One-cycle strobe from the converter stub |
| smp_data | input | 8 | Result value presented with the strobe |
| drdy_n | output | 1 | Data ready, active low |
| pwr_mode | output | 2 | 0 standby, 1 conversion, 2 power-down, 3 settling |

## Verification
A corrupted mode register shows on `pwr_mode` within one cycle of the command byte completing. A wrong settling count shows as the exit from mode 3 happening earlier or later than the exact cycle it is expected on. A failed filter lock or a lost register value stays hidden until the next read shifts it out on MISO. The bench therefore reads back after every write in each mode. A wrong data-ready state shows on `drdy_n` one cycle after the strobe or the result-read command.

// File: rtl/cvc_pkg.sv
// Shared types and command codes for the converter command controller.
// Assumes 8-bit command frames; upper two bits 01/10 mark register writes/reads.
package cvc_pkg;

    typedef enum logic [1:0] {
        M_STBY = 2'd0,
        M_CONV = 2'd1,
        M_PDN  = 2'd2,
        M_SETL = 2'd3
    } mode_e;

    localparam logic [7:0] OP_RESET = 8'h01;
    localparam logic [7:0] OP_WAKE  = 8'h02;
    localparam logic [7:0] OP_PDN   = 8'h04;
    localparam logic [7:0] OP_START = 8'h08;
    localparam logic [7:0] OP_STOP  = 8'h0A;
    localparam logic [7:0] OP_CAL   = 8'h0C;

    localparam logic [1:0] KIND_WR = 2'b01;
    localparam logic [1:0] KIND_RD = 2'b10;

endpackage

// File: rtl/cvc_spi_slave.sv
// SPI mode-0 byte receiver/transmitter running on the core clock.
// Assumes SCK half-period of at least four core cycles; inputs are
// double-flopped here. Raising chip-select clears any partial byte.
module cvc_spi_slave #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              rx_vld,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [1:0]        rx_idx,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [1:0]        cs_m, sck_m, mo_m;
    logic              sck_d;
    logic              cs_s, rise, fall;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] sh, tx_sh;
    logic [1:0]        idx;

    // Two-flop synchronizers and SCK edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_m  <= 2'b11;
            sck_m <= 2'b00;
            mo_m  <= 2'b00;
            sck_d <= 1'b0;
        end else begin
            cs_m  <= {cs_m[0], cs_n};
            sck_m <= {sck_m[0], sck};
            mo_m  <= {mo_m[0], mosi};
            sck_d <= sck_m[1];
        end
    end

    assign cs_s = cs_m[1];
    assign rise = ~cs_s & sck_m[1] & ~sck_d;
    assign fall = ~cs_s & ~sck_m[1] & sck_d;

    // Shift in on rising edges and report each completed byte with its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; sh <= '0; idx <= '0;
            rx_vld <= 1'b0; rx_byte <= '0; rx_idx <= '0;
        end else begin
            rx_vld <= 1'b0;
            if (cs_s) begin
                cnt <= '0;
                idx <= '0;
            end else if (rise) begin
                sh <= {sh[BYTE_W-2:0], mo_m[1]};
                if (cnt == LAST) begin
                    cnt     <= '0;
                    rx_vld  <= 1'b1;
                    rx_byte <= {sh[BYTE_W-2:0], mo_m[1]};
                    rx_idx  <= idx;
                    if (idx != 2'd3) idx <= idx + 2'd1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Output shifter: loaded after a read command, advanced on falling edges inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tx_sh <= '0;
        else if (tx_load)            tx_sh <= tx_data;
        else if (fall && cnt != '0)  tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        else if (cs_s)               tx_sh <= '0;
    end

    assign miso = ~cs_s & tx_sh[BYTE_W-1];

    a_r3_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (cnt == '0));
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> !rx_vld);

endmodule

// File: rtl/cvc_mode_fsm.sv
// Operating-mode state machine with settling timer.
// Assumes cmd_vld pulses once per completed command byte. A START or
// CALIBRATE seen while settling is held and applied when the timer ends.
module cvc_mode_fsm
    import cvc_pkg::*;
#(
    parameter int SETTLE_CYC = 12500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_vld,
    input  logic [7:0] cmd,
    output mode_e      mode
);
    localparam int TW = $clog2(SETTLE_CYC + 1);
    localparam logic [TW-1:0] TLAST = TW'(SETTLE_CYC - 1);

    mode_e         st;
    logic [TW-1:0] tmr;
    logic          pend;
    logic          go, halt, pdn, wake, rst_cmd;

    assign go      = cmd_vld && (cmd == OP_START || cmd == OP_CAL);
    assign halt    = cmd_vld && cmd == OP_STOP;
    assign pdn     = cmd_vld && cmd == OP_PDN;
    assign wake    = cmd_vld && cmd == OP_WAKE;
    assign rst_cmd = cmd_vld && cmd == OP_RESET;

    // Mode transitions, settling count and pending-start bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= M_SETL; tmr <= '0; pend <= 1'b0;
        end else begin
            unique case (st)
                M_SETL: begin
                    if (pdn) begin
                        st <= M_PDN; pend <= 1'b0;
                    end else if (tmr == TLAST) begin
                        st   <= (pend || go) ? M_CONV : M_STBY;
                        tmr  <= '0;
                        pend <= 1'b0;
                    end else begin
                        tmr <= tmr + 1'b1;
                        if (go)                  pend <= 1'b1;
                        else if (halt || rst_cmd) pend <= 1'b0;
                    end
                end
                M_STBY: begin
                    if (go)       st <= M_CONV;
                    else if (pdn) st <= M_PDN;
                end
                M_CONV: begin
                    if (pdn)                   st <= M_PDN;
                    else if (halt || rst_cmd)  st <= M_STBY;
                end
                M_PDN: begin
                    if (wake) begin
                        st <= M_SETL; tmr <= '0;
                    end
                end
                default: st <= M_STBY;
            endcase
        end
    end

    assign mode = st;

    a_r6_pdn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_PDN && !wake) |=> st == M_PDN);
    a_r4_stby_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_STBY && !cmd_vld) |=> st == M_STBY);
    a_r2_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_SETL && tmr != TLAST && !pdn) |=> st == M_SETL);

endmodule

// File: rtl/cvc_regfile.sv
// Configuration registers, result holder and data-ready flag.
// Assumes mode comes from the mode FSM; applies the filter-register lock,
// power-down write/reset blocking and strobe acceptance only in conversion.
module cvc_regfile
    import cvc_pkg::*;
#(
    parameter int           DW       = 8,
    parameter int           NREG     = 4,
    parameter int           AW       = 6,
    parameter int           FILT_IDX = 1,
    parameter logic [DW-1:0] FILT_DEF = 8'h05
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  mode_e                   mode,
    input  logic                    soft_rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic                    rd_clr,
    input  logic                    smp_stb,
    input  logic [DW-1:0]           smp_data,
    output logic [NREG-1:0][DW-1:0] regs,
    output logic [DW-1:0]           result,
    output logic                    drdy_n
);
    localparam logic [AW-1:0] NREG_A = AW'(NREG);
    localparam logic [AW-1:0] FILT_A = AW'(FILT_IDX);

    logic wr_ok, rst_ok, take;

    assign rst_ok = soft_rst && mode != M_PDN;
    assign wr_ok  = wr_en && mode != M_PDN && wr_addr < NREG_A &&
                    !(mode == M_CONV && wr_addr == FILT_A);
    assign take   = smp_stb && mode == M_CONV;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] DFLT = (g == FILT_IDX) ? FILT_DEF : '0;
        // One configuration register: default on any reset, else accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n || rst_ok)                     regs[g] <= DFLT;
            else if (wr_ok && wr_addr == AW'(g))      regs[g] <= wr_data;
        end
    end

    // Result capture and active-low data-ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_ok) begin
            result <= '0; drdy_n <= 1'b1;
        end else if (take) begin
            result <= smp_data; drdy_n <= 1'b0;
        end else if (rd_clr) begin
            drdy_n <= 1'b1;
        end
    end

    a_r8_filt_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_CONV && wr_en && wr_addr == FILT_A && !soft_rst) |=> $stable(regs[FILT_IDX]));
    a_r9_pdn_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PDN) |=> $stable(regs));
    a_r11_rdy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != M_CONV && drdy_n) |=> drdy_n);
    a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !take) |=> drdy_n);

endmodule

// File: rtl/cvc_core.sv
// Top of the converter command controller: SPI framing, command decode,
// mode FSM and register file. Assumes core clock >= 8x SPI clock.
module cvc_core
    import cvc_pkg::*;
#(
    parameter int CORE_KHZ  = 50000,
    parameter int SETTLE_US = 250,
    parameter int NREG      = 4,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sck,
    input  logic          spi_mosi,
    output logic          spi_miso,
    input  logic          smp_stb,
    input  logic [DW-1:0] smp_data,
    output logic          drdy_n,
    output logic [1:0]    pwr_mode
);
    localparam int SETTLE_CYC = CORE_KHZ * SETTLE_US / 1000;
    localparam int AW  = 6;
    localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [AW-1:0] RES_ADDR = 6'h20;
    localparam logic [AW-1:0] NREG_A   = AW'(NREG);

    logic                    rx_vld, tx_load, cmd_vld, dat_vld, wr_en, rd_clr, soft_rst;
    logic [7:0]              rx_byte, cmd_q, tx_data;
    logic [1:0]              rx_idx;
    logic [AW-1:0]           rd_addr;
    mode_e                   mode;
    logic [NREG-1:0][DW-1:0] regs;
    logic [DW-1:0]           result;

    cvc_spi_slave #(.BYTE_W(8)) u_spi (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
        .miso(spi_miso), .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_idx(rx_idx),
        .tx_load(tx_load), .tx_data(tx_data)
    );

    assign cmd_vld = rx_vld && rx_idx == 2'd0;
    assign dat_vld = rx_vld && rx_idx == 2'd1;

    // Hold the command byte so the following data byte can be routed.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (cmd_vld) cmd_q <= rx_byte;
    end

    assign wr_en    = dat_vld && cmd_q[7:6] == KIND_WR;
    assign soft_rst = cmd_vld && rx_byte == OP_RESET;
    assign rd_addr  = rx_byte[5:0];
    assign tx_load  = cmd_vld && rx_byte[7:6] == KIND_RD;
    assign rd_clr   = tx_load && rd_addr == RES_ADDR && mode != M_PDN;

    // Select the byte shifted out after a read command.
    always_comb begin
        if (mode == M_PDN)            tx_data = '0;
        else if (rd_addr == RES_ADDR) tx_data = result;
        else if (rd_addr < NREG_A)    tx_data = regs[rd_addr[RIW-1:0]];
        else                          tx_data = '0;
    end

    cvc_mode_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(rx_byte), .mode(mode)
    );

    cvc_regfile #(.DW(DW), .NREG(NREG), .AW(AW), .FILT_IDX(1), .FILT_DEF(8'h05)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(cmd_q[5:0]), .wr_data(rx_byte), .rd_clr(rd_clr),
        .smp_stb(smp_stb), .smp_data(smp_data), .regs(regs), .result(result),
        .drdy_n(drdy_n)
    );

    assign pwr_mode = mode;

    a_r10_reset_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && mode == M_CONV) |=> (pwr_mode == 2'd0 && drdy_n));

endmodule

// File: tb/sim_cvc_core.sv
// Vector-table bench for cvc_core followed by directed corner tests.
module sim_cvc_core;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int SETTLE     = 300;
    localparam int NV         = 18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, stb = 1'b0;
    logic [7:0] sdat = '0;
    logic miso, drdy_n;
    logic [1:0] pwr_mode;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvc_core #(.CORE_KHZ(1200), .SETTLE_US(250)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .smp_stb(stb), .smp_data(sdat), .drdy_n(drdy_n), .pwr_mode(pwr_mode)
    );

    // {cmd, data, mode, exp_rx, two_bytes, check_rx, req}
    localparam logic [31:0] VEC [NV] = '{
        {8'h40, 8'h3C, 2'd0, 8'h00, 1'b1, 1'b0, 4'd7},  // R7 write reg0
        {8'h80, 8'h00, 2'd0, 8'h3C, 1'b1, 1'b1, 4'd7},  // R7 read reg0
        {8'h41, 8'hA7, 2'd0, 8'h00, 1'b1, 1'b0, 4'd7},  // R7 write filter in standby
        {8'h81, 8'h00, 2'd0, 8'hA7, 1'b1, 1'b1, 4'd7},  // R7
        {8'h33, 8'h00, 2'd0, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 undefined code
        {8'h08, 8'h00, 2'd1, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 start
        {8'h41, 8'h11, 2'd1, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 locked write
        {8'h81, 8'h00, 2'd1, 8'hA7, 1'b1, 1'b1, 4'd8},  // R8
        {8'h42, 8'h5A, 2'd1, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 other reg writable
        {8'h82, 8'h00, 2'd1, 8'h5A, 1'b1, 1'b1, 4'd8},  // R8
        {8'h0A, 8'h00, 2'd0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 stop
        {8'h0C, 8'h00, 2'd1, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 calibrate
        {8'h08, 8'h00, 2'd1, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 start keeps converting
        {8'h04, 8'h00, 2'd2, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 power-down
        {8'h40, 8'hFF, 2'd2, 8'h00, 1'b1, 1'b0, 4'd6},  // R6 write ignored
        {8'h80, 8'h00, 2'd2, 8'h00, 1'b1, 1'b1, 4'd6},  // R6 read gives zero
        {8'h08, 8'h00, 2'd2, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 start ignored
        {8'h01, 8'h00, 2'd2, 8'h00, 1'b0, 1'b0, 4'd6}   // R6 reset ignored
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            wait_clk(H);
            r[i] = miso;
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input bit two,
                        output logic [7:0] rx);
        logic [7:0] junk;
        rx = '0;
        cs_n = 1'b0;
        wait_clk(H);
        spi_byte(b0, junk);
        if (two) spi_byte(b1, rx);
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(H + 4);
    endtask

    task automatic strobe(input logic [7:0] d);
        @(negedge clk); stb = 1'b1; sdat = d;
        @(negedge clk); stb = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        logic [7:0] rx;
        logic [7:0] junk;
        wait_clk(4);
        check("R1", {30'd0, pwr_mode}, 32'd3);
        rst_n = 1'b1;
        check("R1", {31'd0, drdy_n}, 32'd1);
        check("R1", {31'd0, miso}, 32'd0);
        repeat (SETTLE - 1) @(posedge clk);
        @(negedge clk);
        check("R2 still settling", {30'd0, pwr_mode}, 32'd3);
        @(negedge clk);
        check("R2 settle exit", {30'd0, pwr_mode}, 32'd0);
        xfer(8'h81, 8'h00, 1'b1, rx); check("R1 filter default", rx, 32'h05);
        xfer(8'h83, 8'h00, 1'b1, rx); check("R1 reg3 default", rx, 32'h00);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] e;
            e = VEC[v];
            xfer(e[31:24], e[23:16], e[5], rx);
            check($sformatf("R%0d vec%0d mode", e[3:0], v), {30'd0, pwr_mode}, {30'd0, e[15:14]});
            if (e[4]) check($sformatf("R%0d vec%0d rx", e[3:0], v), rx, {24'd0, e[13:6]});
        end

        // R6 / R2: wake-up, then start pending during settling
        xfer(8'h02, 8'h00, 1'b0, rx);
        check("R6 wake to settling", {30'd0, pwr_mode}, 32'd3);
        xfer(8'h08, 8'h00, 1'b0, rx);
        check("R2 start held while settling", {30'd0, pwr_mode}, 32'd3);
        wait_clk(250);
        check("R2 pending start applied", {30'd0, pwr_mode}, 32'd1);

        // R9: retention across power-down
        xfer(8'h80, 8'h00, 1'b1, rx); check("R9 reg0 kept", rx, 32'h3C);
        xfer(8'h81, 8'h00, 1'b1, rx); check("R9 reg1 kept", rx, 32'hA7);
        xfer(8'h82, 8'h00, 1'b1, rx); check("R9 reg2 kept", rx, 32'h5A);

        // R11 / R12: data-ready handshake
        check("R11 idle flag", {31'd0, drdy_n}, 32'd1);
        strobe(8'h9E);
        check("R11 strobe sets ready", {31'd0, drdy_n}, 32'd0);
        xfer(8'hA0, 8'h00, 1'b1, rx);
        check("R12 result value", rx, 32'h9E);
        check("R12 read clears flag", {31'd0, drdy_n}, 32'd1);
        strobe(8'h21);
        xfer(8'h0A, 8'h00, 1'b0, rx);
        strobe(8'h77);
        xfer(8'hA0, 8'h00, 1'b1, rx);
        check("R11 standby strobe ignored", rx, 32'h21);
        check("R12 flag high after read", {31'd0, drdy_n}, 32'd1);
        strobe(8'h55);
        check("R11 flag stays high in standby", {31'd0, drdy_n}, 32'd1);
        xfer(8'hA0, 8'h00, 1'b1, rx);
        check("R12 last result in standby", rx, 32'h21);

        // R10: reset command from conversion
        xfer(8'h08, 8'h00, 1'b0, rx);
        strobe(8'h44);
        check("R11 ready before reset", {31'd0, drdy_n}, 32'd0);
        xfer(8'h01, 8'h00, 1'b0, rx);
        check("R10 mode standby", {30'd0, pwr_mode}, 32'd0);
        check("R10 flag high", {31'd0, drdy_n}, 32'd1);
        xfer(8'h80, 8'h00, 1'b1, rx); check("R10 reg0 default", rx, 32'h00);
        xfer(8'h81, 8'h00, 1'b1, rx); check("R10 filter default", rx, 32'h05);
        xfer(8'hA0, 8'h00, 1'b1, rx); check("R10 result cleared", rx, 32'h00);

        // R3: aborted partial frame then a clean START
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < 4; i++) begin
            mosi = i[0] ? 1'b0 : 1'b1;
            wait_clk(H); sck = 1'b1; wait_clk(H); sck = 1'b0;
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(H + 4);
        check("R3 partial byte no effect", {30'd0, pwr_mode}, 32'd0);
        xfer(8'h08, 8'h00, 1'b0, junk);
        check("R3 frame realigned", {30'd0, pwr_mode}, 32'd1);
        xfer(8'h04, 8'h00, 1'b0, junk);
        check("R5 pdn from conversion", {30'd0, pwr_mode}, 32'd2);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule